// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block turns one request on a simple parallel interface into the complete serial byte traffic that a standard SPI NOR flash expects. The requester gives an operation (identification read, data read, page program or sector erase), a 24-bit address and a byte count. It then supplies program data or collects read data through strobed byte streams. Each flash command is framed by its own chip-select low period. A serial engine shifts bytes in SPI mode 0 with the most significant bit first.

For program and erase, the requester issues a single command. The sequencer puts a separate write-enable frame in front of the command. After the command it reads the status register in repeated frames until the busy bit clears. A poll limit turns a flash that never becomes ready into an error. Consecutive frames are separated by a guaranteed chip-select high time. The serial clock is an even division of the system clock.

Top module: `flash_nor_sequencer`

## Requirements
- R1: After reset, spiCsN is 1, spiSclk is 0, and busy, done and error are 0.
- R2: Operation code 0 (identification) sends one frame holding only byte 0x9F and clocks three more bytes. Those three bytes come out on rdData with one rdValid pulse each, in arrival order (manufacturer, memory type, capacity).
- R3: Operation code 1 (data read) sends one frame holding 0x03 and then the address as three bytes, bits 23:16 first. It then clocks in reqLen bytes, and each byte is delivered with one rdValid pulse.
- R4: Operation code 2 (page program) sends a frame holding only 0x06. The next frame holds 0x02, the address (high byte first) and reqLen data bytes. Each data byte is the value on wrData at the time it is taken, and it is acknowledged afterwards by a one-cycle wrTake pulse.
- R5: Operation code 3 (sector erase) sends a frame holding only 0x06, followed by a frame of exactly four bytes: 0x20 and the address high byte first.
- R6: After the program or erase frame, the block repeats two-byte frames of 0x05 followed by one read byte. It keeps repeating until bit 0 of the read byte is 0, looks at no other bit, and raises done only after that last status frame has closed.
- R7: A page program with reqLen of 0 or above 256 completes with done and error together. It produces no chip-select activity and no wrTake pulse.
- R8: The serial clock idles low whenever spiCsN is high. Bits go out MSB first, with spiMosi stable across each rising edge of spiSclk, and spiMiso is sampled on that rising edge.
- R9: spiCsN stays high for at least CS_GAP system clock cycles between any two frames.
- R10: A reqValid that arrives while busy is high is ignored. It causes no frame and no extra done.
- R11: If the busy bit is still set after POLL_LIMIT status frames, the block stops polling and completes with error set.
- R12: busy rises only in the cycle after a request is accepted. busy stays high through a done pulse that lasts exactly one cycle, and it falls right after that pulse. error is only high together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while idle |
| reqOp | input | 2 | 0 identification, 1 read, 2 program, 3 erase |
| reqAddr | input | 24 | Flash byte address |
| reqLen | input | LEN_W | Byte count for read and program |
| wrData | input | 8 | Current program byte |
| wrTake | output | 1 | Pulse: current program byte was consumed |
| rdData | output | 8 | Received data byte |
| rdValid | output | 1 | Pulse: rdData holds a new byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Failure flag, valid with done |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiCsN | output | 1 | Active-low chip select |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The bench places a bit-level flash model on the serial pins and checks every frame byte by byte. A wrong bit order or wrong sampling edge would therefore show up as garbled commands, garbled addresses or garbled read data. The status model reports busy for a chosen number of polls and sets an unrelated bit when the flash is ready. This catches a design that finishes before the busy bit clears, and a design that tests the whole status byte instead of bit 0. Page lengths of 0, 256 and 257 check that the limit is applied exactly, and that a rejected program leaves chip select untouched. A flash that never becomes ready must end in exactly POLL_LIMIT polls and an error. A request issued during a read must not start a second transfer.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_IDENT = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } flashOp_e;

  typedef enum logic [1:0] {
    FR_WREN,
    FR_MAIN,
    FR_POLL
  } frameKind_e;

  localparam logic [7:0] CMD_IDENT  = 8'h9F;
  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_STATUS = 8'h05;

  // strobes from the command FSM to the serial datapath
  typedef struct packed {
    logic       csOn;
    logic       csOff;
    logic       load;
    logic [7:0] txByte;
  } spiStrobe_t;

endpackage

// File: rtl/flash_spi_shifter.sv
module flash_spi_shifter
  import flash_seq_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiStrobe_t strobe,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       csN,
  output logic       byteDone,
  output logic [7:0] rxByte
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF - 1);

  logic              active;
  logic [HALF_W-1:0] divCnt;
  logic [2:0]        bitCnt;
  logic [7:0]        shTx;
  logic [7:0]        shRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN      <= 1'b1;
      sclk     <= 1'b0;
      active   <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shTx     <= '0;
      shRx     <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobe.csOn)  csN <= 1'b0;
      if (strobe.csOff) csN <= 1'b1;
      if (strobe.load) begin
        active <= 1'b1;
        shTx   <= strobe.txByte;
        divCnt <= '0;
        bitCnt <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (divCnt == HALF_LAST) begin
          divCnt <= '0;
          if (!sclk) begin
            // rising edge: capture the incoming bit
            sclk <= 1'b1;
            shRx <= {shRx[6:0], miso};
          end else begin
            // falling edge: present the next outgoing bit
            sclk   <= 1'b0;
            shTx   <= {shTx[6:0], 1'b0};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + HALF_W'(1);
        end
      end
    end
  end

  assign mosi   = shTx[7];
  assign rxByte = shRx;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int CS_GAP     = 2,
  parameter int POLL_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  output spiStrobe_t       strobe,
  output logic             wrTake,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             error
);

  localparam int CNT_W  = LEN_W + 3;
  localparam int GAP_W  = $clog2(CS_GAP + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(CS_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CSON, S_LOAD, S_SHIFT, S_CSOFF, S_GAP, S_DONE
  } ctrlState_e;

  ctrlState_e  state;
  frameKind_e  frame;
  flashOp_e    opQ;
  logic [23:0]      addrQ;
  logic [LEN_W-1:0] lenQ;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] total;
  logic [GAP_W-1:0] gapCnt;
  logic [POLL_W-1:0] pollCnt;
  logic errFlag;
  logic flashBusy;
  logic isData;
  logic badLen;
  logic [7:0] txSel;

  function automatic logic [7:0] opCommand(flashOp_e op);
    case (op)
      OP_IDENT: return CMD_IDENT;
      OP_READ:  return CMD_READ;
      OP_PROG:  return CMD_PROG;
      default:  return CMD_ERASE;
    endcase
  endfunction

  always_comb begin
    unique case (frame)
      FR_WREN: total = CNT_W'(1);
      FR_POLL: total = CNT_W'(2);
      default: total = (opQ == OP_READ || opQ == OP_PROG) ?
                       CNT_W'(4) + CNT_W'(lenQ) : CNT_W'(4);
    endcase
  end

  assign isData = (frame == FR_MAIN) &&
                  ((opQ == OP_IDENT) ? (idx != '0) : (idx >= CNT_W'(4)));

  always_comb begin
    txSel = 8'h00;
    unique case (frame)
      FR_WREN: txSel = CMD_WREN;
      FR_POLL: txSel = (idx == '0) ? CMD_STATUS : 8'h00;
      default: begin
        if (idx == '0)                txSel = opCommand(opQ);
        else if (opQ == OP_IDENT)     txSel = 8'h00;
        else if (idx == CNT_W'(1))    txSel = addrQ[23:16];
        else if (idx == CNT_W'(2))    txSel = addrQ[15:8];
        else if (idx == CNT_W'(3))    txSel = addrQ[7:0];
        else if (opQ == OP_PROG)      txSel = wrData;
      end
    endcase
  end

  assign badLen = (reqLen == '0) || (reqLen > LEN_W'(PAGE_BYTES));

  always_comb begin
    strobe        = '0;
    strobe.csOn   = (state == S_CSON);
    strobe.csOff  = (state == S_CSOFF);
    strobe.load   = (state == S_LOAD);
    strobe.txByte = txSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      frame     <= FR_MAIN;
      opQ       <= OP_IDENT;
      addrQ     <= '0;
      lenQ      <= '0;
      idx       <= '0;
      gapCnt    <= '0;
      pollCnt   <= '0;
      errFlag   <= 1'b0;
      flashBusy <= 1'b0;
      wrTake    <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      wrTake  <= 1'b0;
      rdValid <= 1'b0;
      unique case (state)
        S_IDLE: if (reqValid) begin
          opQ     <= flashOp_e'(reqOp);
          addrQ   <= reqAddr;
          lenQ    <= reqLen;
          pollCnt <= '0;
          errFlag <= 1'b0;
          if (flashOp_e'(reqOp) == OP_PROG && badLen) begin
            errFlag <= 1'b1;
            state   <= S_DONE;
          end else begin
            frame <= (flashOp_e'(reqOp) == OP_PROG || flashOp_e'(reqOp) == OP_ERASE) ?
                     FR_WREN : FR_MAIN;
            state <= S_CSON;
          end
        end
        S_CSON: begin
          idx   <= '0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          if (isData && opQ == OP_PROG) wrTake <= 1'b1;
          state <= S_SHIFT;
        end
        S_SHIFT: if (byteDone) begin
          if (isData && opQ != OP_PROG) begin
            rdValid <= 1'b1;
            rdData  <= rxByte;
          end
          if (frame == FR_POLL && idx == CNT_W'(1)) flashBusy <= rxByte[0];
          if (idx == total - CNT_W'(1)) begin
            state <= S_CSOFF;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= S_LOAD;
          end
        end
        S_CSOFF: begin
          gapCnt <= '0;
          state  <= S_GAP;
        end
        S_GAP: begin
          if (gapCnt == GAP_LAST) begin
            unique case (frame)
              FR_WREN: begin
                frame <= FR_MAIN;
                state <= S_CSON;
              end
              FR_MAIN: begin
                if (opQ == OP_PROG || opQ == OP_ERASE) begin
                  frame   <= FR_POLL;
                  pollCnt <= '0;
                  state   <= S_CSON;
                end else begin
                  state <= S_DONE;
                end
              end
              default: begin
                if (!flashBusy) begin
                  state <= S_DONE;
                end else if (pollCnt == POLL_LAST) begin
                  errFlag <= 1'b1;
                  state   <= S_DONE;
                end else begin
                  pollCnt <= pollCnt + POLL_W'(1);
                  state   <= S_CSON;
                end
              end
            endcase
          end else begin
            gapCnt <= gapCnt + GAP_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign error = (state == S_DONE) && errFlag;

endmodule

// File: rtl/flash_nor_sequencer.sv
module flash_nor_sequencer
  import flash_seq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int CS_GAP     = 2,
  parameter int CLK_DIV    = 4,
  parameter int POLL_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       wrData,
  output logic             wrTake,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             spiSclk,
  output logic             spiMosi,
  output logic             spiCsN,
  input  logic             spiMiso
);

  spiStrobe_t strobe;
  logic       byteDone;
  logic [7:0] rxByte;

  flash_seq_ctrl #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES),
    .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr), .reqLen(reqLen),
    .wrData(wrData), .byteDone(byteDone), .rxByte(rxByte),
    .strobe(strobe), .wrTake(wrTake), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .done(done), .error(error)
  );

  flash_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rstN(rstN), .strobe(strobe), .miso(spiMiso),
    .sclk(spiSclk), .mosi(spiMosi), .csN(spiCsN),
    .byteDone(byteDone), .rxByte(rxByte)
  );

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
  parameter int CS_GAP = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic done,
  input logic error,
  input logic rdValid,
  input logic wrTake,
  input logic spiSclk,
  input logic spiCsN
);

  localparam int HI_W = $clog2(CS_GAP + 2);
  logic [HI_W-1:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           hiCnt <= '0;
    else if (!spiCsN)                    hiCnt <= '0;
    else if (hiCnt < HI_W'(CS_GAP))      hiCnt <= hiCnt + HI_W'(1);
  end

  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> (hiCnt >= HI_W'(CS_GAP)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R12
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  // R10
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R12
  error_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R2
  rd_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (busy && !spiCsN));

  // R4
  wr_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrTake |-> (busy && !spiCsN));

endmodule

bind flash_nor_sequencer flash_seq_checker #(.CS_GAP(CS_GAP)) u_seqChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done),
  .error(error), .rdValid(rdValid), .wrTake(wrTake),
  .spiSclk(spiSclk), .spiCsN(spiCsN)
);

// File: tb/test_flash_nor_sequencer.sv
module test_flash_nor_sequencer;

  localparam int LEN_W      = 16;
  localparam int CS_GAP     = 2;
  localparam int POLL_LIMIT = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [23:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0] wrData;
  logic wrTake;
  logic [7:0] rdData;
  logic rdValid, busy, done, error;
  logic spiSclk, spiMosi, spiCsN, spiMiso;

  always #5 clk = ~clk;

  flash_nor_sequencer #(.LEN_W(LEN_W), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT))
    i_flash_nor_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqLen(reqLen), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done), .error(error),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN), .spiMiso(spiMiso)
  );

  int nChecks = 0;
  int nFail   = 0;

  function automatic logic [7:0] rdPat(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] wrPat(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  // ---------------- flash model and monitors (single writer) ----------------
  logic [7:0] byteLog [0:2047];
  int frameStart [0:511];
  int frameCnt = 0, byteCnt = 0, rdCnt = 0, wrTakes = 0, doneCnt = 0;
  int badEdges = 0, statusSeen = 0, bitIdx = 0, hiRun = 1000, minGap = 1000;
  logic [7:0] rdLog [0:63];
  logic [7:0] inShift = '0, outReg = '0, curCmd = '0;
  logic [23:0] curAddr = '0;
  logic prevCs = 1'b1, prevSclk = 1'b0;
  int busyPolls = 0;   // written by tasks only
  int wrBase = 0;      // written by tasks only

  assign spiMiso = outReg[7];
  assign wrData  = wrPat(wrTakes - wrBase);

  function automatic logic [7:0] respond(int n);
    case (curCmd)
      8'h9F: return (n == 1) ? 8'hEF : (n == 2) ? 8'h40 : (n == 3) ? 8'h18 : 8'h00;
      8'h03: return (n >= 4) ? rdPat(curAddr + 24'(n - 4)) : 8'h00;
      8'h05: return (n == 1) ? ((statusSeen < busyPolls) ? 8'h03 : 8'h02) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!spiCsN && prevCs) begin
      if (hiRun < minGap) minGap = hiRun;
      frameStart[frameCnt] = byteCnt;
      frameCnt++;
      bitIdx = 0; outReg = '0; curCmd = '0; curAddr = '0;
    end
    if (spiCsN && !prevCs && curCmd == 8'h05) statusSeen++;
    hiRun = spiCsN ? hiRun + 1 : 0;
    if (spiSclk != prevSclk && spiCsN) badEdges++;
    if (!spiCsN && spiSclk && !prevSclk) begin
      inShift = {inShift[6:0], spiMosi};
      bitIdx++;
      if (bitIdx % 8 == 0) begin
        byteLog[byteCnt] = inShift;
        byteCnt++;
        if (bitIdx == 8) begin
          curCmd = inShift;
          if (inShift == 8'h06) statusSeen = 0;
        end else if (bitIdx <= 32) begin
          curAddr = {curAddr[15:0], inShift};
        end
      end
    end
    if (!spiCsN && !spiSclk && prevSclk) begin
      if (bitIdx % 8 == 0) outReg = respond(bitIdx / 8);
      else                 outReg = {outReg[6:0], 1'b0};
    end
    if (rdValid) begin
      if (rdCnt < 64) rdLog[rdCnt] = rdData;
      rdCnt++;
    end
    if (wrTake) wrTakes++;
    if (done) doneCnt++;
    prevCs = spiCsN;
    prevSclk = spiSclk;
  end

  function automatic int frameLen(int f);
    return ((f + 1 < frameCnt) ? frameStart[f + 1] : byteCnt) - frameStart[f];
  endfunction

  function automatic logic [7:0] fByte(int f, int k);
    return byteLog[frameStart[f] + k];
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [23:0] a, input int len);
    @(negedge clk);
    reqOp = op; reqAddr = a; reqLen = LEN_W'(len); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit gotErr, output bit ok);
    int n = 0;
    ok = 1'b0; gotErr = 1'b0;
    while (n < 30000 && !ok) begin
      if (done) begin ok = 1'b1; gotErr = error; end
      else begin @(negedge clk); n++; end
    end
    @(negedge clk);
  endtask

  task automatic checkHeader(input int f, input logic [7:0] cmd,
                             input logic [23:0] a, input string req);
    check(fByte(f, 0) == cmd, req, "command byte", fByte(f, 0), cmd);
    check({fByte(f, 1), fByte(f, 2), fByte(f, 3)} == a, req, "address MSB first",
          {fByte(f, 1), fByte(f, 2), fByte(f, 3)}, a);
  endtask

  task automatic checkPolls(input int f0, input int nPoll, input string req);
    int bad = 0;
    for (int f = f0; f < f0 + nPoll; f++)
      if (frameLen(f) != 2 || fByte(f, 0) != 8'h05) bad++;
    check(bad == 0, req, "malformed status frames", bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    check(spiCsN === 1'b1 && spiSclk === 1'b0, "R1", "bus idle after reset",
          {spiCsN, spiSclk}, 2'b10);
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "flags after reset",
          {busy, done, error}, 0);
  endtask

  task automatic testIdent();
    int f0 = frameCnt, r0 = rdCnt, d0 = doneCnt;
    bit e, ok;
    issue(2'd0, 24'h123456, 0);
    check(busy === 1'b1, "R12", "busy after accept", busy, 1);
    waitDone(e, ok);
    check(ok && !e, "R2", "ident completes", {ok, e}, 2'b10);
    check(frameCnt - f0 == 1 && frameLen(f0) == 4 && fByte(f0, 0) == 8'h9F,
          "R2", "ident frame", fByte(f0, 0), 8'h9F);
    check(rdCnt - r0 == 3 && rdLog[r0] == 8'hEF && rdLog[r0+1] == 8'h40 &&
          rdLog[r0+2] == 8'h18, "R2", "ident bytes",
          {rdLog[r0], rdLog[r0+1], rdLog[r0+2]}, 24'hEF4018);
    check(doneCnt - d0 == 1 && busy === 1'b0, "R12", "single done then idle",
          doneCnt - d0, 1);
  endtask

  task automatic testRead(input logic [23:0] a, input int len);
    int f0 = frameCnt, r0 = rdCnt, bad = 0;
    bit e, ok;
    issue(2'd1, a, len);
    waitDone(e, ok);
    check(ok && !e && frameCnt - f0 == 1 && frameLen(f0) == 4 + len,
          "R3", "read frame shape", frameLen(f0), 4 + len);
    checkHeader(f0, 8'h03, a, "R3");
    for (int i = 0; i < len; i++)
      if (rdLog[r0 + i] != rdPat(a + 24'(i))) bad++;
    check(rdCnt - r0 == len && bad == 0, "R3", "read data stream", bad, 0);
  endtask

  task automatic testProgram(input logic [23:0] a, input int len, input int polls);
    int f0 = frameCnt, bad = 0;
    bit e, ok;
    busyPolls = polls;
    wrBase = wrTakes;
    issue(2'd2, a, len);
    waitDone(e, ok);
    check(ok && !e, "R4", "program completes clean", {ok, e}, 2'b10);
    check(frameLen(f0) == 1 && fByte(f0, 0) == 8'h06, "R4", "write-enable frame",
          fByte(f0, 0), 8'h06);
    check(frameLen(f0 + 1) == 4 + len, "R4", "program frame length",
          frameLen(f0 + 1), 4 + len);
    checkHeader(f0 + 1, 8'h02, a, "R4");
    for (int i = 0; i < len; i++)
      if (fByte(f0 + 1, 4 + i) != wrPat(i)) bad++;
    check(bad == 0 && wrTakes - wrBase == len, "R4", "program payload",
          wrTakes - wrBase, len);
    check(frameCnt - f0 == 2 + polls + 1, "R6", "status polls until bit0 clear",
          frameCnt - f0, 3 + polls);
    checkPolls(f0 + 2, polls + 1, "R6");
  endtask

  task automatic testErase(input logic [23:0] a, input int polls);
    int f0 = frameCnt;
    bit e, ok;
    busyPolls = polls;
    issue(2'd3, a, 0);
    waitDone(e, ok);
    check(ok && !e, "R5", "erase completes clean", {ok, e}, 2'b10);
    check(frameLen(f0) == 1 && fByte(f0, 0) == 8'h06 && frameLen(f0 + 1) == 4,
          "R5", "erase frame shapes", frameLen(f0 + 1), 4);
    checkHeader(f0 + 1, 8'h20, a, "R5");
    check(frameCnt - f0 == 2 + polls + 1, "R6", "erase polls", frameCnt - f0, 3 + polls);
  endtask

  task automatic testBadLen(input int len);
    int f0 = frameCnt, w0 = wrTakes;
    bit e, ok;
    issue(2'd2, 24'h000100, len);
    waitDone(e, ok);
    check(ok && e, "R7", "bad length flagged", {ok, e}, 2'b11);
    check(frameCnt == f0 && wrTakes == w0, "R7", "no bus activity", frameCnt - f0, 0);
  endtask

  task automatic testTimeout();
    int f0 = frameCnt;
    bit e, ok;
    busyPolls = 100000;
    issue(2'd3, 24'h00F000, 0);
    waitDone(e, ok);
    check(ok && e, "R11", "timeout error", {ok, e}, 2'b11);
    check(frameCnt - f0 == 2 + POLL_LIMIT, "R11", "poll count at limit",
          frameCnt - f0, 2 + POLL_LIMIT);
  endtask

  task automatic testIgnore();
    int f0 = frameCnt, d0 = doneCnt;
    bit e, ok;
    issue(2'd1, 24'h0000F0, 2);
    repeat (20) @(negedge clk);
    reqOp = 2'd0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone(e, ok);
    repeat (200) @(negedge clk);
    check(frameCnt - f0 == 1 && fByte(f0, 0) == 8'h03, "R10", "request while busy dropped",
          frameCnt - f0, 1);
    check(doneCnt - d0 == 1 && busy === 1'b0, "R10", "one done only", doneCnt - d0, 1);
  endtask

  bit wdFail = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    wdFail = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testIdent();
    testRead(24'hABCDEF, 5);
    testRead(24'h00FFFE, 1);
    testProgram(24'h012300, 4, 2);
    testProgram(24'h020000, 256, 0);
    testErase(24'h345000, 1);
    testBadLen(0);
    testBadLen(257);
    testTimeout();
    testIgnore();
    check(badEdges == 0, "R8", "sclk moved while deselected", badEdges, 0);
    check(minGap >= CS_GAP, "R9", "chip-select high gap", minGap, CS_GAP);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule